// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB display panel. From a fast source clock it derives a pixel-rate enable with a programmable divider. On that enable it steps a horizontal pixel counter and a vertical line counter. From the two counters it decodes horizontal sync, vertical sync and a data-enable window. The current pixel and line positions are output so that a downstream pixel fetcher can address its frame store.

Software programs the block through a write-only register port. Each axis has four timing fields: active length, front porch, sync width and back porch. Every field holds the wanted count minus one. Writes land in a staged copy. While the generator runs, the staged copy moves into the working copy only at the first pixel of the vertical sync line, so a frame is never drawn with a half-updated geometry. While it is stopped, the working copy follows the staged copy one cycle later.

At that same vertical sync point, a frame event can raise a one-cycle pulse and set a sticky pending bit. Software clears the pending bit by writing one to it. The block has no pixel data path, so there is no streaming interface. Every pin is a plain control or status level.

Top module: `vtg_top`

## Requirements
- R1: Register addresses 0..3 hold horizontal active, front porch, sync and back porch, and addresses 4..7 hold the vertical ones. Each is stored as count minus one. The pixel counter runs 0 to (a+f+s+b+3) of its axis and then wraps to 0. The line counter advances when the pixel counter wraps.
- R2: On each axis the regions follow in this order: active (0..a), front porch, sync, back porch. `de` is high only when the generator runs and both counters lie in their active regions.
- R3: Address 8 is the control word. Bit 4 inverts hsync and bit 5 inverts vsync. With both bits clear, sync is active-high. While stopped, each sync output sits at its inactive level.
- R4: Address 9 holds the divider minus one (d). `pix_ce` is high once every d+1 source cycles. The counters change only on cycles that follow a `pix_ce`.
- R5: While running, writes to the timing fields, run (control bit 0) and polarity take effect together at the first pixel of the first vsync line. While stopped, they take effect on the cycle after the write.
- R6: At that vsync point, if control bit 1 (interrupt enable) and bit 2 (frame source select) are both set, `frame_pulse` is high for exactly one source cycle and `irq_pend` is set. If either bit is clear, neither happens.
- R7: Writing a word with bit 0 set to address 10 clears `irq_pend`. Writing 0 there leaves it set. A frame event in the same cycle wins over the clear.
- R8: Writing control bit 3 is a one-shot soft reset. Both counters return to 0 on the next cycle, and the pending bit and the pulse are cleared.
- R9: While the working run bit is 0, both counters stay at 0 and `de` is low.
- R10: After `rst_n` is asserted, the counters are 0, the generator is stopped, and `de`, `hsync`, `vsync`, `frame_pulse` and `irq_pend` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | FIELD_W | Register write data |
| pix_ce | output | 1 | Pixel-rate enable |
| pix_x | output | FIELD_W+2 | Current pixel within the line |
| pix_y | output | FIELD_W+2 | Current line within the frame |
| de | output | 1 | Data enable, active area |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| frame_pulse | output | 1 | One-cycle frame event |
| irq_pend | output | 1 | Sticky frame pending bit |

## Verification
The counters come straight out of their registers. A wrong step or wrap therefore shows at `pix_x`/`pix_y` on the first pixel enable after the fault, and a bad region boundary shows as a misplaced `de` or sync edge within the same line. A shadow copy that loads too early shows as a changed line length before the vsync line. A pending bit that is mishandled shows at the next frame event or at the next clear write. The bench sweeps every position of small frames under several dividers, polarities and geometries, and compares each cycle against positions and regions computed arithmetically.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int ADDR_W = 4;
  localparam int N_TIM  = 8;

  localparam logic [ADDR_W-1:0] A_H_ACT = 4'd0;
  localparam logic [ADDR_W-1:0] A_V_ACT = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd10;

  localparam int C_RUN  = 0;
  localparam int C_IRQ  = 1;
  localparam int C_FSEL = 2;
  localparam int C_SRST = 3;
  localparam int C_HINV = 4;
  localparam int C_VINV = 5;

  typedef enum logic [1:0] {SEG_ACT, SEG_FP, SEG_SYNC, SEG_BP} seg_e;
endpackage

// File: rtl/vtg_pixdiv.sv
module vtg_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_m1,
  output logic             ce
);
  logic [DIV_W-1:0] cnt;

  // >= keeps the counter bounded when the divisor shrinks mid-count
  assign ce = (cnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (ce)     cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis import vtg_pkg::*; #(
  parameter int FIELD_W = 12,
  parameter int CNT_W   = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [FIELD_W-1:0] act_m1,
  input  logic [FIELD_W-1:0] fp_m1,
  input  logic [FIELD_W-1:0] sync_m1,
  input  logic [FIELD_W-1:0] bp_m1,
  output logic [CNT_W-1:0]   cnt,
  output seg_e               seg,
  output logic               at_last,
  output logic               at_fp_end
);
  logic [CNT_W-1:0] e_act, e_fp, e_sync, e_last;

  always_comb begin
    e_act  = CNT_W'(act_m1);
    e_fp   = e_act  + CNT_W'(fp_m1)   + CNT_W'(1);
    e_sync = e_fp   + CNT_W'(sync_m1) + CNT_W'(1);
    e_last = e_sync + CNT_W'(bp_m1)   + CNT_W'(1);
  end

  always_comb begin
    if (cnt <= e_act)       seg = SEG_ACT;
    else if (cnt <= e_fp)   seg = SEG_FP;
    else if (cnt <= e_sync) seg = SEG_SYNC;
    else                    seg = SEG_BP;
  end

  assign at_last   = (cnt >= e_last);
  assign at_fp_end = (cnt == e_fp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= at_last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs import vtg_pkg::*; #(
  parameter int FIELD_W = 12,
  parameter int DIV_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [FIELD_W-1:0]            wr_data,
  input  logic                          load,
  output logic [N_TIM-1:0][FIELD_W-1:0] tim_w,
  output logic                          run_w,
  output logic                          hinv_w,
  output logic                          vinv_w,
  output logic                          irq_en,
  output logic                          frm_sel,
  output logic [DIV_W-1:0]              div_m1,
  output logic                          srst,
  output logic                          clr_wr
);
  logic [N_TIM-1:0][FIELD_W-1:0] tim_s;
  logic run_s, hinv_s, vinv_s;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign srst    = ctrl_wr && wr_data[C_SRST];
  assign clr_wr  = wr_en && (wr_addr == A_STAT) && wr_data[0];

  for (genvar i = 0; i < N_TIM; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tim_s[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(i)))
        tim_s[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s   <= 1'b0;
      hinv_s  <= 1'b0;
      vinv_s  <= 1'b0;
      irq_en  <= 1'b0;
      frm_sel <= 1'b0;
    end else if (ctrl_wr) begin
      run_s   <= wr_data[C_RUN];
      hinv_s  <= wr_data[C_HINV];
      vinv_s  <= wr_data[C_VINV];
      irq_en  <= wr_data[C_IRQ];
      frm_sel <= wr_data[C_FSEL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_m1 <= '0;
    else if (wr_en && (wr_addr == A_DIV))
      div_m1 <= wr_data[DIV_W-1:0];
  end

  // working copy: follows staged while stopped, else only at the vsync point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_w  <= '0;
      run_w  <= 1'b0;
      hinv_w <= 1'b0;
      vinv_w <= 1'b0;
    end else if (!run_w || load) begin
      tim_w  <= tim_s;
      run_w  <= run_s;
      hinv_w <= hinv_s;
      vinv_w <= vinv_s;
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top import vtg_pkg::*; #(
  parameter int FIELD_W = 12,
  parameter int DIV_W   = 8,
  localparam int CNT_W  = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [FIELD_W-1:0] cfg_wdata,
  output logic               pix_ce,
  output logic [CNT_W-1:0]   pix_x,
  output logic [CNT_W-1:0]   pix_y,
  output logic               de,
  output logic               hsync,
  output logic               vsync,
  output logic               frame_pulse,
  output logic               irq_pend
);
  logic [N_TIM-1:0][FIELD_W-1:0] tim_w;
  logic run_w, hinv_w, vinv_w, irq_en, frm_sel, srst, clr_wr;
  logic [DIV_W-1:0] div_m1;
  seg_e hseg, vseg;
  logic h_last, h_fpe, v_last, v_fpe;
  logic frame_evt, cnt_clr, h_step, v_step, set_pend;

  vtg_regs #(.FIELD_W(FIELD_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .load(frame_evt), .tim_w(tim_w), .run_w(run_w),
    .hinv_w(hinv_w), .vinv_w(vinv_w), .irq_en(irq_en), .frm_sel(frm_sel),
    .div_m1(div_m1), .srst(srst), .clr_wr(clr_wr)
  );

  vtg_pixdiv #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .clr(srst), .div_m1(div_m1), .ce(pix_ce)
  );

  assign cnt_clr   = srst || !run_w;
  assign h_step    = run_w && pix_ce;
  assign v_step    = h_step && h_last;
  assign frame_evt = v_step && v_fpe;
  assign set_pend  = frame_evt && irq_en && frm_sel;

  vtg_axis #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) hax_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(h_step),
    .act_m1(tim_w[0]), .fp_m1(tim_w[1]), .sync_m1(tim_w[2]), .bp_m1(tim_w[3]),
    .cnt(pix_x), .seg(hseg), .at_last(h_last), .at_fp_end(h_fpe)
  );

  vtg_axis #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) vax_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(v_step),
    .act_m1(tim_w[4]), .fp_m1(tim_w[5]), .sync_m1(tim_w[6]), .bp_m1(tim_w[7]),
    .cnt(pix_y), .seg(vseg), .at_last(v_last), .at_fp_end(v_fpe)
  );

  assign de    = run_w && (hseg == SEG_ACT) && (vseg == SEG_ACT);
  assign hsync = run_w ? ((hseg == SEG_SYNC) ^ hinv_w) : hinv_w;
  assign vsync = run_w ? ((vseg == SEG_SYNC) ^ vinv_w) : vinv_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_pulse <= 1'b0;
      irq_pend    <= 1'b0;
    end else if (srst) begin
      frame_pulse <= 1'b0;
      irq_pend    <= 1'b0;
    end else begin
      frame_pulse <= set_pend;
      if (set_pend)    irq_pend <= 1'b1;
      else if (clr_wr) irq_pend <= 1'b0;
    end
  end

  logic unused_last;
  assign unused_last = v_last;
endmodule

// File: rtl/vtg_top_chk.sv
module vtg_top_chk #(
  parameter int FIELD_W = 12,
  parameter int CNT_W   = FIELD_W + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_ce,
  input logic [CNT_W-1:0]   pix_x,
  input logic [CNT_W-1:0]   pix_y,
  input logic               de,
  input logic               frame_pulse,
  input logic               irq_pend,
  input logic               run_w,
  input logic               srst,
  input logic               clr_wr,
  input logic               frame_evt,
  input logic [FIELD_W-1:0] h_act_m1,
  input logic [FIELD_W-1:0] v_act_m1
);
  assert_de_in_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x <= CNT_W'(h_act_m1)) && (pix_y <= CNT_W'(v_act_m1)));

  assert_hold_without_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && run_w && !srst) |=> $stable(pix_x) && $stable(pix_y));

  assert_stopped_at_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> (pix_x == '0) && (pix_y == '0));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pix_x == '0) && (pix_y == '0) && !irq_pend && !frame_pulse);

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !frame_evt) |=> !irq_pend);

  assert_pend_rise_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> frame_pulse);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);
endmodule

bind vtg_top vtg_top_chk #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .pix_x(pix_x), .pix_y(pix_y),
  .de(de), .frame_pulse(frame_pulse), .irq_pend(irq_pend), .run_w(run_w),
  .srst(srst), .clr_wr(clr_wr), .frame_evt(frame_evt),
  .h_act_m1(tim_w[0]), .v_act_m1(tim_w[4])
);

// File: tb/vtg_top_tb_top.sv
module vtg_top_tb_top;
  import vtg_pkg::*;
  localparam int CLK_P = 10;
  localparam int FW    = 12;
  localparam int CW    = FW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [FW-1:0] cfg_wdata = '0;
  logic pix_ce, de, hsync, vsync, frame_pulse, irq_pend;
  logic [CW-1:0] pix_x, pix_y;

  always #(CLK_P/2) clk = ~clk;

  vtg_top #(.FIELD_W(FW), .DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_ce(pix_ce), .pix_x(pix_x), .pix_y(pix_y),
    .de(de), .hsync(hsync), .vsync(vsync), .frame_pulse(frame_pulse),
    .irq_pend(irq_pend)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // bench model of the register state
  int stg_t[8], stgp_t[8], cur_t[8];
  bit stg_run, stgp_run, cur_run, stg_hi, stgp_hi, cur_hi, stg_vi, stgp_vi, cur_vi;
  bit m_ie, m_fs;
  int m_div;
  bit mon_on = 0, gap_rst = 0;
  int pulses = 0;

  // monitor state
  bit prev_ok = 0, prev_ce = 0, prev_run = 0, gap_ok = 0;
  int prev_x, prev_y, prev_hl, prev_vl, gap;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int htot(input int g[8]); return g[0]+g[1]+g[2]+g[3]+4; endfunction
  function automatic int vtot(input int g[8]); return g[4]+g[5]+g[6]+g[7]+4; endfunction

  always @(negedge clk) begin
    if (!mon_on) begin
      prev_ok = 0;
      gap_ok  = 0;
    end else begin
      int px, py, hss, hse, vss, vse;
      bit first_vs, e_de, e_hs, e_vs, e_p;
      px = int'(pix_x);
      py = int'(pix_y);
      vss = cur_t[4] + cur_t[5] + 2;
      first_vs = prev_ok && cur_run && (py == vss) && (px == 0) && (py != prev_y);
      e_p = first_vs && m_ie && m_fs;
      // R5: working copy reloads at the vsync point, or every cycle while stopped
      if (first_vs || !cur_run) begin
        cur_t = stgp_t; cur_run = stgp_run; cur_hi = stgp_hi; cur_vi = stgp_vi;
      end
      hss = cur_t[0] + cur_t[1] + 2;  hse = hss + cur_t[2];
      vss = cur_t[4] + cur_t[5] + 2;  vse = vss + cur_t[6];
      e_de = cur_run && (px <= cur_t[0]) && (py <= cur_t[4]);
      e_hs = cur_run ? ((px >= hss && px <= hse) ^ cur_hi) : cur_hi;
      e_vs = cur_run ? ((py >= vss && py <= vse) ^ cur_vi) : cur_vi;
      chk(de == e_de, "R2 data enable window", de, e_de);
      chk(hsync == e_hs, "R3 hsync level", hsync, e_hs);
      chk(vsync == e_vs, "R3 vsync level", vsync, e_vs);
      chk(frame_pulse == e_p, "R6 frame pulse", frame_pulse, e_p);
      if (frame_pulse) pulses++;
      if (prev_ok) begin
        if (!prev_run) begin
          chk(px == 0, "R9 stopped pixel", px, 0);
          chk(py == 0, "R9 stopped line", py, 0);
        end else if (prev_ce) begin
          int ex, ey;
          ex = (prev_x == prev_hl) ? 0 : prev_x + 1;
          ey = (prev_x == prev_hl) ? ((prev_y == prev_vl) ? 0 : prev_y + 1) : prev_y;
          chk(px == ex, "R1 pixel step", px, ex);
          chk(py == ey, "R1 line step", py, ey);
        end else begin
          chk(px == prev_x && py == prev_y, "R4 hold between enables", px, prev_x);
        end
      end
      if (gap_rst) begin gap_ok = 0; gap_rst = 0; end
      if (pix_ce) begin
        if (gap_ok) chk(gap == m_div + 1, "R4 enable spacing", gap, m_div + 1);
        gap = 1; gap_ok = 1;
      end else gap++;
      prev_x = px; prev_y = py; prev_ce = pix_ce; prev_run = cur_run;
      prev_hl = htot(cur_t) - 1; prev_vl = vtot(cur_t) - 1; prev_ok = 1;
      stgp_t = stg_t; stgp_run = stg_run; stgp_hi = stg_hi; stgp_vi = stg_vi;
    end
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = FW'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_tim(input int i, input int v);
    wr(4'(i), v);
    stg_t[i] = v;
  endtask

  task automatic set_ctrl(input bit run, input bit ie, input bit fs, input bit sr,
                          input bit hi, input bit vi);
    wr(A_CTRL, (int'(run) << C_RUN) | (int'(ie) << C_IRQ) | (int'(fs) << C_FSEL) |
               (int'(sr) << C_SRST) | (int'(hi) << C_HINV) | (int'(vi) << C_VINV));
    stg_run = run; m_ie = ie; m_fs = fs; stg_hi = hi; stg_vi = vi;
  endtask

  task automatic set_div(input int d);
    wr(A_DIV, d); m_div = d; gap_rst = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (stg_t[i]) begin stg_t[i] = 0; stgp_t[i] = 0; cur_t[i] = 0; end
    m_div = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(pix_x == 0, "R10 reset pixel", int'(pix_x), 0);
    chk(pix_y == 0, "R10 reset line", int'(pix_y), 0);
    chk(!de && !hsync && !vsync, "R10 reset outputs", int'({de, hsync, vsync}), 0);
    chk(!frame_pulse && !irq_pend, "R10 reset irq", int'({frame_pulse, irq_pend}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // geometry A, divide by 2, interrupt fully enabled (R1 R2 R4 R6)
    set_tim(0, 2); set_tim(1, 0); set_tim(2, 1); set_tim(3, 0);
    set_tim(4, 1); set_tim(5, 0); set_tim(6, 0); set_tim(7, 1);
    set_div(1);
    set_ctrl(1, 1, 1, 0, 0, 0);
    idle(300);
    chk(irq_pend == 1'b1, "R6 pending after frames", irq_pend, 1);
    chk(pulses >= 2, "R6 pulses seen", pulses, 2);

    // stop (takes effect at vsync), then stopped state R9
    set_ctrl(0, 1, 1, 0, 0, 0);
    idle(200);
    chk(pix_x == 0 && pix_y == 0, "R9 stopped origin", int'(pix_x), 0);
    chk(de == 1'b0, "R9 stopped de", de, 0);

    // R7 write-one-to-clear
    wr(A_STAT, 0);
    @(negedge clk);
    chk(irq_pend == 1'b1, "R7 zero write keeps pending", irq_pend, 1);
    wr(A_STAT, 1);
    @(negedge clk);
    chk(irq_pend == 1'b0, "R7 one write clears pending", irq_pend, 0);

    // R3 polarity while stopped
    set_ctrl(0, 1, 0, 0, 1, 1);
    idle(2);
    chk(hsync == 1'b1, "R3 inverted idle hsync", hsync, 1);
    chk(vsync == 1'b1, "R3 inverted idle vsync", vsync, 1);

    // geometry B, no divide, inverted, frame select off (R3 R6)
    set_tim(0, 3); set_tim(1, 1); set_tim(2, 0); set_tim(3, 2);
    set_tim(4, 2); set_tim(5, 1); set_tim(6, 1); set_tim(7, 0);
    set_div(0);
    set_ctrl(1, 1, 0, 0, 1, 1);
    idle(300);
    chk(irq_pend == 1'b0, "R6 no pending with select off", irq_pend, 0);

    // R5 shadowed change while running
    idle(7);
    set_tim(0, 0);
    set_tim(3, 4);
    idle(300);

    // divider 3 with interrupts on
    set_div(2);
    set_ctrl(1, 1, 1, 0, 0, 1);
    idle(500);
    chk(irq_pend == 1'b1, "R6 pending before soft reset", irq_pend, 1);

    // R8 soft reset
    mon_on = 0;
    @(negedge clk);
    while (pix_x == 0) @(negedge clk);
    set_ctrl(1, 1, 1, 1, 0, 1);
    @(negedge clk);
    chk(pix_x == 0, "R8 soft reset pixel", int'(pix_x), 0);
    chk(pix_y == 0, "R8 soft reset line", int'(pix_y), 0);
    chk(irq_pend == 1'b0, "R8 soft reset pending", irq_pend, 0);
    gap_rst = 1;
    mon_on = 1;
    idle(300);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule